// File: doc/BRIEF.md
# Four-Byte Page Write Buffer

This block sits between the serial front-end of a small byte-wide non-volatile memory and its 512 x 8 storage array. While a write instruction is being shifted in, it gathers the data bytes into a four-slot page latch. Each slot is steered by the low two bits of a running address. The upper address bits come from the start address and never change. Once a byte is loaded, its slot is marked valid. When more than four bytes arrive, the slot index wraps around, and later bytes replace the earlier ones in the same slots.

When chip select rises, the front-end reports two things: whether the rise fell exactly on a byte boundary, and whether the protection logic allows the write. If both are true and at least one slot holds data, the block writes every valid slot into the array. It writes one byte per clock, starting with the lowest slot, and then pulses a completion flag. Any other rise of chip select throws the page away. No erase step exists: each programmed byte simply replaces the old array content. A falling edge of chip select starts a new instruction. It clears the valid mask and the slot index.

Data bytes enter on a valid/ready stream. A byte is taken on a clock where both `in_valid` and `in_ready` are high. `in_ready` drops for the whole programming phase, and the sender must hold the byte until it is accepted. All other inputs are single-cycle strobes. During programming the block ignores the chip-select strobes and the address load.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `mem_we`, `prog_done` and `prog_busy` are 0 and `in_ready` is 1.
- R2: A byte accepted after an address load of A goes to array address {A[8:2], (A[1:0]+k) mod 4}, where k is the number of bytes accepted before it in the same instruction. Bits 8:2 never change inside one page.
- R3: A fifth and any later byte reuses slot index 0 relative to the start. The array receives only the last value loaded into each slot, and writes it once.
- R4: Only slots that received a byte are written. A partial page produces exactly as many array writes as distinct slots loaded.
- R5: After an accepted commit, the array writes begin on the next clock, one per clock with no gaps, in ascending slot order (low address bits 0 to 3). `prog_done` is high for exactly one cycle, the cycle after the last write.
- R6: A `cs_rise` with `rise_aligned`=0 discards the page. No array write and no `prog_done` follow, and a later aligned commit with no new bytes writes nothing.
- R7: A `cs_rise` with `write_permit`=0 discards the page in the same way, with no write and no `prog_done`.
- R8: `cs_fall` clears the valid mask and the slot index. Bytes loaded before it are never written.
- R9: While `prog_busy` is 1, `in_ready` is 0. A byte offered then is not taken, and the array data is unchanged by it.
- R10: An aligned, permitted commit with an empty page produces no write, no `prog_done` and no busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_fall | input | 1 | Strobe: chip select went low (new instruction) |
| addr_load | input | 1 | Strobe: start address on `addr_in` is valid |
| addr_in | input | 9 | Start byte address |
| in_valid | input | 1 | Data byte on `in_data` is offered |
| in_ready | output | 1 | Buffer can take a byte this cycle |
| in_data | input | 8 | Data byte |
| cs_rise | input | 1 | Strobe: chip select went high |
| rise_aligned | input | 1 | Qualifier for `cs_rise`: the rise came right after a byte's last bit |
| write_permit | input | 1 | Qualifier for `cs_rise`: protection allows this write |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 9 | Array write address |
| mem_wdata | output | 8 | Array write data |
| prog_done | output | 1 | One-cycle pulse after the last array write |
| prog_busy | output | 1 | Array update in progress |

## Verification
The hardest case to reach from the ports is a page whose slots were filled out of address order and partly overwritten. The array writes must still come out in ascending slot order, and each slot must carry only its last value. The stimulus starts pages at non-zero low address bits, and it sends five bytes so the index wraps onto a slot that is already valid. It also offers bytes while programming is in progress, and it re-commits a page that was just discarded, to show that no stale slot comes back.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_PROG = 1'b1
  } seq_state_e;
endpackage

// File: rtl/page_slot_latch.sv
module page_slot_latch #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 4,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clr,
  input  logic                                 addr_load,
  input  logic [ADDR_W-1:0]                    addr_in,
  input  logic                                 take,
  input  logic [DATA_W-1:0]                    data_in,
  output logic [ADDR_W-IDX_W-1:0]              base_o,
  output logic [PAGE_BYTES-1:0]                mask_o,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]    slots_o
);
  logic [IDX_W-1:0] idx_q;

  // running slot index and page base
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      base_o <= '0;
    end else if (addr_load) begin
      idx_q  <= addr_in[IDX_W-1:0];
      base_o <= addr_in[ADDR_W-1:IDX_W];
    end else if (clr) begin
      idx_q  <= '0;
    end else if (take) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  // one data register and one valid bit per slot
  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots_o[s] <= '0;
        mask_o[s]  <= 1'b0;
      end else if (clr) begin
        mask_o[s]  <= 1'b0;
      end else if (take && idx_q == IDX_W'(s)) begin
        slots_o[s] <= data_in;
        mask_o[s]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/page_commit_seq.sv
module page_commit_seq
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES = 4,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [PAGE_BYTES-1:0] mask_in,
  output logic                  busy,
  output logic                  we,
  output logic [IDX_W-1:0]      pick,
  output logic                  done
);
  seq_state_e            state_q;
  logic [PAGE_BYTES-1:0] pend_q;
  logic [PAGE_BYTES-1:0] pick_1h;
  logic [PAGE_BYTES-1:0] pend_nxt;

  // lowest pending slot wins
  always_comb begin
    pick = '0;
    for (int i = PAGE_BYTES - 1; i >= 0; i--) begin
      if (pend_q[i]) pick = IDX_W'(i);
    end
  end

  assign pick_1h  = PAGE_BYTES'(1) << pick;
  assign pend_nxt = pend_q & ~pick_1h;
  assign busy     = (state_q == SEQ_PROG);
  assign we       = busy && (pend_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SEQ_IDLE: if (go) begin
          pend_q  <= mask_in;
          state_q <= SEQ_PROG;
        end
        SEQ_PROG: begin
          pend_q <= pend_nxt;
          if (pend_nxt == '0) begin
            state_q <= SEQ_IDLE;
            done    <= 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 4,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cs_rise,
  input  logic              rise_aligned,
  input  logic              write_permit,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              prog_done,
  output logic              prog_busy
);
  logic [ADDR_W-IDX_W-1:0]              base;
  logic [PAGE_BYTES-1:0]                mask;
  logic [PAGE_BYTES-1:0][DATA_W-1:0]    slots;
  logic [IDX_W-1:0]                     pick;
  logic                                 busy;
  logic                                 go;
  logic                                 clr;

  // strobes are honoured only while idle
  assign in_ready = !busy;
  assign clr      = (cs_fall || cs_rise) && !busy;
  assign go       = cs_rise && rise_aligned && write_permit && !busy && (mask != '0);

  page_slot_latch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .addr_load(addr_load && !busy),
    .addr_in  (addr_in),
    .take     (in_valid && in_ready),
    .data_in  (in_data),
    .base_o   (base),
    .mask_o   (mask),
    .slots_o  (slots)
  );

  page_commit_seq #(
    .PAGE_BYTES(PAGE_BYTES)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .mask_in(mask),
    .busy   (busy),
    .we     (mem_we),
    .pick   (pick),
    .done   (prog_done)
  );

  assign prog_busy = busy;
  assign mem_addr  = {base, pick};
  assign mem_wdata = slots[pick];
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              cs_rise,
  input logic              rise_aligned,
  input logic              write_permit,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              prog_done,
  input logic              prog_busy
);
  // R9: no byte can be taken while the array is written
  a_r9_no_accept_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !in_ready);

  // R5: completion pulse lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !prog_done);

  // R5: completion follows the final write directly
  a_r5_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> ($past(mem_we) && !mem_we));

  // R6 / R7: a burst of writes starts only after a qualified commit
  a_r6_start_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(cs_rise && rise_aligned && write_permit));

  // R2: page bits stay fixed across a burst
  a_r2_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:2] == $past(mem_addr[ADDR_W-1:2])));

  // R5: slots go out in ascending order
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[1:0] > $past(mem_addr[1:0])));

  // R5: writes only inside the busy window
  a_r5_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> prog_busy);
endmodule

bind page_write_buffer pwb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .cs_rise     (cs_rise),
  .rise_aligned(rise_aligned),
  .write_permit(write_permit),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .prog_done   (prog_done),
  .prog_busy   (prog_busy)
);

// File: tb/sim_page_write_buffer.sv
`timescale 1ns/1ps
module sim_page_write_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_fall = 1'b0, addr_load = 1'b0, in_valid = 1'b0;
  logic [8:0] addr_in = '0;
  logic [7:0] in_data = '0;
  logic       cs_rise = 1'b0, rise_aligned = 1'b0, write_permit = 1'b0;
  logic       in_ready, mem_we, prog_done, prog_busy;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata;

  int n_chk = 0, n_bad = 0;
  int wn = 0, dn = 0, bad_rdy = 0;
  logic [8:0] la [0:15];
  logic [7:0] ld [0:15];
  logic first_we;

  always #2 clk = ~clk;

  page_write_buffer u0 (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .addr_load(addr_load),
    .addr_in(addr_in), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cs_rise(cs_rise), .rise_aligned(rise_aligned), .write_permit(write_permit),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .prog_done(prog_done), .prog_busy(prog_busy)
  );

  always @(negedge clk) begin
    if (mem_we && wn < 16) begin
      la[wn] = mem_addr;
      ld[wn] = mem_wdata;
      wn++;
    end
    if (prog_done) dn++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic new_instr(input logic [8:0] a);
    cs_fall = 1'b1; @(negedge clk); cs_fall = 1'b0;
    addr_in = a; addr_load = 1'b1; @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_commit(input bit al, input bit pm, input bit stuff);
    wn = 0; dn = 0; bad_rdy = 0;
    cs_rise = 1'b1; rise_aligned = al; write_permit = pm;
    @(negedge clk);
    cs_rise = 1'b0;
    first_we = mem_we;
    for (int i = 0; i < 10; i++) begin
      if (prog_busy && in_ready) bad_rdy++;
      in_valid = stuff && prog_busy;
      in_data  = 8'hFF;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic check_log(input string tag, input int n,
                           input logic [8:0] ea [0:3], input logic [7:0] ed [0:3]);
    chk({tag, " write count"}, wn, n);
    for (int i = 0; i < n && i < wn; i++) begin
      chk({tag, " addr"}, la[i], ea[i]);
      chk({tag, " data"}, ld[i], ed[i]);
    end
    chk({tag, " done pulses"}, dn, (n > 0) ? 1 : 0);
  endtask

  task automatic t_reset();
    chk("R1 mem_we", mem_we, 0);
    chk("R1 prog_done", prog_done, 0);
    chk("R1 prog_busy", prog_busy, 0);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_full_page();
    logic [8:0] ea [0:3] = '{9'h0E4, 9'h0E5, 9'h0E6, 9'h0E7};
    logic [7:0] ed [0:3] = '{8'hA2, 8'hA3, 8'hA0, 8'hA1};
    new_instr(9'h0E6);
    for (int i = 0; i < 4; i++) send_byte(8'hA0 + 8'(i));
    do_commit(1, 1, 1);
    chk("R5 first write next clock", first_we, 1);
    check_log("R2 R5 full page", 4, ea, ed);
    chk("R9 ready low while busy", bad_rdy, 0);
    chk("R9 ready back", in_ready, 1);
  endtask

  task automatic t_partial();
    logic [8:0] ea [0:3] = '{9'h1FD, 9'h1FE, 9'h0, 9'h0};
    logic [7:0] ed [0:3] = '{8'h5A, 8'hC3, 8'h0, 8'h0};
    new_instr(9'h1FD);
    send_byte(8'h5A); send_byte(8'hC3);
    do_commit(1, 1, 0);
    check_log("R4 partial page", 2, ea, ed);
  endtask

  task automatic t_wrap();
    logic [8:0] ea [0:3] = '{9'h040, 9'h041, 9'h042, 9'h043};
    logic [7:0] ed [0:3] = '{8'h55, 8'h22, 8'h33, 8'h44};
    new_instr(9'h040);
    for (int i = 1; i <= 5; i++) send_byte(8'(i * 8'h11));
    do_commit(1, 1, 0);
    check_log("R3 wrap", 4, ea, ed);
  endtask

  task automatic t_misaligned();
    logic [8:0] ea [0:3] = '{default: '0};
    logic [7:0] ed [0:3] = '{default: '0};
    new_instr(9'h080);
    send_byte(8'h77); send_byte(8'h78);
    do_commit(0, 1, 0);
    check_log("R6 misaligned", 0, ea, ed);
    do_commit(1, 1, 0);
    check_log("R6 R10 recommit empty", 0, ea, ed);
    chk("R10 no busy", prog_busy, 0);
  endtask

  task automatic t_refused();
    logic [8:0] ea [0:3] = '{default: '0};
    logic [7:0] ed [0:3] = '{default: '0};
    new_instr(9'h100);
    send_byte(8'h12);
    do_commit(1, 0, 0);
    check_log("R7 refused", 0, ea, ed);
  endtask

  task automatic t_restart();
    logic [8:0] ea [0:3] = '{9'h123, 9'h0, 9'h0, 9'h0};
    logic [7:0] ed [0:3] = '{8'h9C, 8'h0, 8'h0, 8'h0};
    new_instr(9'h010);
    for (int i = 0; i < 3; i++) send_byte(8'h30 + 8'(i));
    new_instr(9'h123);
    send_byte(8'h9C);
    do_commit(1, 1, 0);
    check_log("R8 cs_fall clears", 1, ea, ed);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_page();
    t_partial();
    t_wrap();
    t_misaligned();
    t_refused();
    t_restart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule